// File: doc/BRIEF.md
# Lookahead Adder-Subtractor with Overflow Detection

This block adds or subtracts two two's complement operands of a parameterised width (eight bits by default) in a single combinational path. A mode input chooses the operation. For subtraction the second operand is bit-wise inverted by an XOR with the mode bit. The mode bit also enters as the carry into bit zero, so the datapath computes A + not(B) + 1 without a separate subtractor.

Every bit position forms a propagate term (A xor B') and a generate term (A and B'). All carries, including the carry out of the top bit, are computed in parallel from these terms and the shared carry-in. No carry waits on the stage below it. Each sum bit is the propagate term XORed with the carry into that position.

Two flags come with the result. The carry flag is the raw carry out of the top bit in both modes, so after a subtraction it reads 1 when no borrow occurred. The overflow flag marks a signed result that does not fit the word. It is the XOR of the carry into the sign bit and the carry out of it.

Top module: `cla_addsub`

## Requirements
- R1: With `sub` = 0, `res` equals (`a` + `b`) modulo 2^W.
- R2: With `sub` = 1, `res` equals (`a` - `b`) modulo 2^W, formed as `a` + not(`b`) + 1.
- R3: With `sub` = 0, `cout` is 1 exactly when the unsigned sum `a` + `b` is at least 2^W.
- R4: With `sub` = 1, `cout` is 1 exactly when `a` >= `b` as unsigned numbers. The carry is not inverted into a borrow.
- R5: `ovf` is 1 exactly when the true signed result, reading bit W-1 as the sign, lies outside the range -2^(W-1) to 2^(W-1)-1. Two positive operands whose sum exceeds the maximum turn the sign bit to 1 and set `ovf`.
- R6: Adding two negatives whose true sum is below the minimum sets `ovf`. For W = 8, 0xC1 (-63) plus 0xB7 (-73) gives `res` = 0x78 (+120) with `ovf` = 1.
- R7: Subtraction overflows in both directions. For W = 8, 0x80 - 0x01 gives 0x7F with `ovf` = 1 and `cout` = 1. 0x00 - 0x80 gives 0x80 with `ovf` = 1 and `cout` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a    | input  | W | First operand, two's complement |
| b    | input  | W | Second operand, two's complement |
| sub  | input  | 1 | 0 selects a + b, 1 selects a - b |
| res  | output | W | Result word, bit W-1 is the sign |
| cout | output | 1 | Carry out of the most significant bit |
| ovf  | output | 1 | Signed overflow flag |

## Verification
The assertions are immediate checks placed in a combinational process. They assume that `a`, `b` and `sub` hold known values whenever the process runs. The bench only ever drives fully defined values, and it sets all three inputs in one assignment before each sampling point. Stimulus covers every combination of both operands and the mode at the default width. Results are sampled half a clock period after each change.

// File: rtl/cla_addsub.sv
module cla_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         ovf
);

  logic [W-1:0] bx;
  logic [W-1:0] p;
  logic [W-1:0] g;
  logic [W:0]   c;

  assign bx   = b ^ {W{sub}};
  assign p    = a ^ bx;
  assign g    = a & bx;
  assign c[0] = sub;

  // Each carry is flattened over the whole prefix, independent of lower carries.
  for (genvar i = 1; i <= W; i++) begin : g_carry
    logic cy;
    always_comb begin
      logic run;
      cy  = g[i-1];
      run = p[i-1];
      for (int j = i - 2; j >= 0; j--) begin
        cy  = cy | (run & g[j]);
        run = run & p[j];
      end
      cy = cy | (run & sub);
    end
    assign c[i] = cy;
  end

  assign res  = p ^ c[W-1:0];
  assign cout = c[W];
  assign ovf  = c[W] ^ c[W-1];

  always_comb begin
    logic [W:0] wide;
    logic       sa, sbx, sr;
    wide = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, sub};
    sa   = a[W-1];
    sbx  = bx[W-1];
    sr   = res[W-1];
    // R1
    add_result_chk: assert (sub || res == W'(a + b));
    // R2
    sub_result_chk: assert (!sub || res == W'(a - b));
    // R3
    add_carry_chk: assert (sub || cout == wide[W]);
    // R4
    sub_carry_chk: assert (!sub || cout == (a >= b));
    // R5
    ovf_sign_chk: assert (ovf == ((sa == sbx) && (sr != sa)));
  end

endmodule

// File: tb/cla_addsub_test.sv
module cla_addsub_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a, b, res;
  logic sub, cout, ovf;
  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cla_addsub #(.W(W)) uut (
    .a(a), .b(b), .sub(sub), .res(res), .cout(cout), .ovf(ovf)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (a=%0h b=%0h sub=%0b)", req, act, exp_v, a, b, sub);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 199000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below 199000 cycles", cycles);
      finish_run();
    end
  end

  task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb, input logic ts);
    @(posedge clk);
    {a, b, sub} = {ta, tb, ts};
    @(negedge clk);
  endtask

  initial begin
    {a, b, sub} = '0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 zero inputs give a zero result and no flags
    check(res == 0 && cout == 0 && ovf == 0, "R1 idle", {res, cout, ovf}, 0);

    // R6 -63 + -73 wraps to +120 with overflow
    apply(8'hC1, 8'hB7, 1'b0);
    check(res == 8'h78, "R6 res", res, 8'h78);
    check(ovf == 1'b1, "R6 ovf", ovf, 1);
    check(cout == 1'b1, "R6 cout", cout, 1);

    // R5 positive overflow flips the sign bit
    apply(8'h64, 8'h39, 1'b0);
    check(res == 8'h9D && ovf == 1'b1, "R5 pos", {res, ovf}, {8'h9D, 1'b1});

    // R7 subtraction overflow in both directions
    apply(8'h80, 8'h01, 1'b1);
    check(res == 8'h7F && ovf && cout, "R7 neg", {res, cout, ovf}, {8'h7F, 2'b11});
    apply(8'h00, 8'h80, 1'b1);
    check(res == 8'h80 && ovf && !cout, "R7 pos", {res, cout, ovf}, {8'h80, 2'b01});

    // Exhaustive sweep
    for (int m = 0; m < 2; m++) begin
      for (int ia = 0; ia < (1 << W); ia++) begin
        for (int ib = 0; ib < (1 << W); ib++) begin
          logic [W-1:0] ey;
          logic         ec, eo;
          int           sa, sb, tr;
          apply(W'(ia), W'(ib), m[0]);
          sa = (ia >= (1 << (W-1))) ? ia - (1 << W) : ia;
          sb = (ib >= (1 << (W-1))) ? ib - (1 << W) : ib;
          tr = m ? sa - sb : sa + sb;
          eo = (tr > (1 << (W-1)) - 1) || (tr < -(1 << (W-1)));
          if (m == 0) begin
            ey = W'(ia + ib);
            ec = (ia + ib) >= (1 << W);
            check(res == ey, "R1", res, ey);
            check(cout == ec, "R3", cout, ec);
          end else begin
            ey = W'(ia - ib);
            ec = ia >= ib;
            check(res == ey, "R2", res, ey);
            check(cout == ec, "R4", cout, ec);
          end
          check(ovf == eo, "R5", ovf, eo);
        end
      end
    end
    finish_run();
  end
endmodule